// File: doc/BRIEF.md
# Dual LED Duty-Cycle Blinker

This block turns a small set of control bits into the drive lines of two indicator lamps, one red and one blue. Each lamp blinks over a repeating period built from a divided clock. A two-bit code per lamp picks what share of each period the lamp is lit: all of it, a half, a quarter or an eighth. When the code asks for a lamp that is always lit, a per-lamp bit can switch on fast 50% pulsing, which halves the average drive current while the lamp still looks steadily on.

Three controls sit above the blink pattern. A per-lamp force-dark bit wins over everything else. The blue lamp can follow an external "data detected" status input in place of its own pattern. A shared slow-down bit doubles the blink period of both lamps. The prescaler that divides the system clock, the blink period width and the pulse rate are all parameters. The lamp outputs are registered.

Top module: `ledblink_top`

## Requirements
- R1: While `rstN` is low both lamp outputs are 0. They stay 0 until the first rising clock edge after `rstN` goes high. The prescaler, the blink counter and the pulse counter all restart from zero at release.
- R2: With duty code 2'b00, the modulate bit clear and no override, the lamp is lit on every cycle.
- R3: With duty code 2'b01, 2'b10 or 2'b11, the lamp is lit only in the first 1/2, 1/4 or 1/8 of each blink period. The period is `PRESCALE_DIV * 2**PERIOD_BITS` clocks. It is measured from the first clock edge after reset.
- R4: While `halfRate` is 1, the blink period of both lamps is doubled. The lit fraction of the period does not change.
- R5: With duty code 2'b00 and the modulate bit set, the lamp follows a 50% square wave with a period of `2**MOD_BITS` clocks. The lamp is lit in the second half of each wave period. The modulate bit has no effect with any other duty code.
- R6: A set force-dark bit keeps its lamp at 0 whatever the other controls are.
- R7: With `blueFollow` set and `blueOff` clear, the blue lamp equals `dataDetect`. `blueFollow` has no effect on the red lamp.
- R8: Each output reflects the inputs sampled at the previous rising clock edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| redDuty | input | 2 | Red duty code (00 full, 01 half, 10 quarter, 11 eighth) |
| blueDuty | input | 2 | Blue duty code, same encoding |
| redModulate | input | 1 | Red fast pulsing at full duty |
| blueModulate | input | 1 | Blue fast pulsing at full duty |
| redOff | input | 1 | Force red dark |
| blueOff | input | 1 | Force blue dark |
| blueFollow | input | 1 | Blue follows dataDetect |
| halfRate | input | 1 | Double both blink periods |
| dataDetect | input | 1 | Music data detected status |
| redLed | output | 1 | Red lamp drive |
| blueLed | output | 1 | Blue lamp drive |

## Verification
Each lamp output is due one clock edge after the inputs it depends on. At edge k after release, the prescaler sits at k mod `PRESCALE_DIV`, the blink count is k / `PRESCALE_DIV` and the pulse count is k mod `2**MOD_BITS`. At each falling edge the bench first compares the outputs with the value it predicted for the edge just past. It then updates the inputs and computes, from its edge counter alone, the value due at the next rising edge. Because inputs only change after that comparison, every check sees exactly one register of latency. That includes the phase changes, the mid-run reset and the toggling of `dataDetect`.

// File: rtl/ledblink_pkg.sv
package ledblink_pkg;

  localparam int LED_RED  = 0;
  localparam int LED_BLUE = 1;
  localparam int NUM_LEDS = 2;

  typedef enum logic [1:0] {
    DUTY_FULL    = 2'b00,
    DUTY_HALF    = 2'b01,
    DUTY_QUARTER = 2'b10,
    DUTY_EIGHTH  = 2'b11
  } dutyCode_t;

  // Timing strobes handed from the counter section to the lamp logic
  typedef struct packed {
    logic inHalf;     // phase within first half of the period
    logic inQuarter;  // phase within first quarter
    logic inEighth;   // phase within first eighth
    logic modWave;    // fast 50% square wave
  } blinkStrobes_t;

endpackage

// File: rtl/ledblink_ctrl.sv
module ledblink_ctrl
  import ledblink_pkg::*;
#(
  parameter int PRESCALE_DIV = 4,
  parameter int PERIOD_BITS  = 6,
  parameter int MOD_BITS     = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          halfRate,
  output blinkStrobes_t strobes
);

  localparam int PRE_W = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
  localparam int CNT_W = PERIOD_BITS + 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE_DIV - 1);

  logic [PRE_W-1:0]    prescCnt;
  logic [CNT_W-1:0]    blinkCnt;
  logic [MOD_BITS-1:0] modCnt;
  logic                prescTick;
  logic [2:0]          phaseTop;

  assign prescTick = (prescCnt == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt <= '0;
      blinkCnt <= '0;
      modCnt   <= '0;
    end else begin
      prescCnt <= prescTick ? '0 : prescCnt + 1'b1;
      if (prescTick) blinkCnt <= blinkCnt + 1'b1;
      modCnt <= modCnt + 1'b1;
    end
  end

  // Slow-down selects the upper slice of the wider counter
  assign phaseTop = halfRate ? blinkCnt[PERIOD_BITS -: 3]
                             : blinkCnt[PERIOD_BITS-1 -: 3];

  always_comb begin
    strobes.inHalf    = (phaseTop[2]   == 1'b0);
    strobes.inQuarter = (phaseTop[2:1] == 2'b00);
    strobes.inEighth  = (phaseTop      == 3'b000);
    strobes.modWave   = modCnt[MOD_BITS-1];
  end

endmodule

// File: rtl/ledblink_datapath.sv
module ledblink_datapath
  import ledblink_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  blinkStrobes_t            strobes,
  input  logic [NUM_LEDS-1:0][1:0] dutyCode,
  input  logic [NUM_LEDS-1:0]      modulate,
  input  logic [NUM_LEDS-1:0]      forceOff,
  input  logic [NUM_LEDS-1:0]      followEn,
  input  logic                     dataDetect,
  output logic [NUM_LEDS-1:0]      ledOut
);

  logic [NUM_LEDS-1:0] nextOn;

  for (genvar g = 0; g < NUM_LEDS; g++) begin : g_lamp
    logic blinkOn;

    always_comb begin
      unique case (dutyCode_t'(dutyCode[g]))
        DUTY_FULL:    blinkOn = modulate[g] ? strobes.modWave : 1'b1;
        DUTY_HALF:    blinkOn = strobes.inHalf;
        DUTY_QUARTER: blinkOn = strobes.inQuarter;
        default:      blinkOn = strobes.inEighth;
      endcase
    end

    // Priority: force-dark, then follow-detect, then blink pattern
    assign nextOn[g] = forceOff[g] ? 1'b0
                     : (followEn[g] ? dataDetect : blinkOn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ledOut <= '0;
    else       ledOut <= nextOn;
  end

endmodule

// File: rtl/ledblink_top.sv
module ledblink_top
  import ledblink_pkg::*;
#(
  parameter int PRESCALE_DIV = 4,
  parameter int PERIOD_BITS  = 6,
  parameter int MOD_BITS     = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] redDuty,
  input  logic [1:0] blueDuty,
  input  logic       redModulate,
  input  logic       blueModulate,
  input  logic       redOff,
  input  logic       blueOff,
  input  logic       blueFollow,
  input  logic       halfRate,
  input  logic       dataDetect,
  output logic       redLed,
  output logic       blueLed
);

  blinkStrobes_t             strobes;
  logic [NUM_LEDS-1:0][1:0]  dutyCode;
  logic [NUM_LEDS-1:0]       modulate;
  logic [NUM_LEDS-1:0]       forceOff;
  logic [NUM_LEDS-1:0]       followEn;
  logic [NUM_LEDS-1:0]       ledOut;

  assign dutyCode[LED_RED]  = redDuty;
  assign dutyCode[LED_BLUE] = blueDuty;
  assign modulate[LED_RED]  = redModulate;
  assign modulate[LED_BLUE] = blueModulate;
  assign forceOff[LED_RED]  = redOff;
  assign forceOff[LED_BLUE] = blueOff;
  assign followEn[LED_RED]  = 1'b0;
  assign followEn[LED_BLUE] = blueFollow;

  ledblink_ctrl #(
    .PRESCALE_DIV(PRESCALE_DIV),
    .PERIOD_BITS (PERIOD_BITS),
    .MOD_BITS    (MOD_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .halfRate(halfRate),
    .strobes (strobes)
  );

  ledblink_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dutyCode  (dutyCode),
    .modulate  (modulate),
    .forceOff  (forceOff),
    .followEn  (followEn),
    .dataDetect(dataDetect),
    .ledOut    (ledOut)
  );

  assign redLed  = ledOut[LED_RED];
  assign blueLed = ledOut[LED_BLUE];

endmodule

// File: rtl/ledblink_chk.sv
module ledblink_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] redDuty,
  input logic       redModulate,
  input logic       redOff,
  input logic       blueOff,
  input logic       blueFollow,
  input logic       dataDetect,
  input logic       quarterWin,
  input logic       modWave,
  input logic       redLed,
  input logic       blueLed
);

  AST_RED_FORCED_DARK: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && redOff) |-> !redLed); // R6

  AST_BLUE_FORCED_DARK: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && blueOff) |-> !blueLed); // R6

  AST_FULL_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && !redOff && redDuty == 2'b00 && !redModulate) |-> redLed); // R2

  AST_QUARTER_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && !redOff && redDuty == 2'b10 && !quarterWin) |-> !redLed); // R3

  AST_MOD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && !redOff && redDuty == 2'b00 && redModulate)
      |-> (redLed == $past(modWave))); // R5

  AST_FOLLOW_DETECT: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && !blueOff && blueFollow)
      |-> (blueLed == $past(dataDetect))); // R7

endmodule

bind ledblink_top ledblink_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .redDuty    (redDuty),
  .redModulate(redModulate),
  .redOff     (redOff),
  .blueOff    (blueOff),
  .blueFollow (blueFollow),
  .dataDetect (dataDetect),
  .quarterWin (strobes.inQuarter),
  .modWave    (strobes.modWave),
  .redLed     (redLed),
  .blueLed    (blueLed)
);

// File: tb/tb_ledblink_top.sv
`timescale 1ns/1ps
module tb_ledblink_top;

  localparam int DIV = 4;
  localparam int PB  = 6;
  localparam int MB  = 2;

  logic clk = 1'b0;
  logic rstN;
  logic [1:0] redDuty, blueDuty;
  logic redModulate, blueModulate, redOff, blueOff, blueFollow, halfRate, dataDetect;
  logic redLed, blueLed;

  int tests = 0;
  int fails = 0;
  int k = 0;
  bit done = 0;
  bit toggleDetect = 0;
  logic expRed = 1'b0, expBlue = 1'b0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  ledblink_top #(.PRESCALE_DIV(DIV), .PERIOD_BITS(PB), .MOD_BITS(MB)) dut (
    .clk(clk), .rstN(rstN), .redDuty(redDuty), .blueDuty(blueDuty),
    .redModulate(redModulate), .blueModulate(blueModulate),
    .redOff(redOff), .blueOff(blueOff), .blueFollow(blueFollow),
    .halfRate(halfRate), .dataDetect(dataDetect),
    .redLed(redLed), .blueLed(blueLed));

  // Behavioural lamp model: value due after clock edge number kk since release
  function automatic logic lampModel(int kk, logic [1:0] duty, logic mdl, logic off,
                                     logic half, logic follow, logic det);
    int per = 1 << PB;
    int p = (kk / DIV) % (2 * per);
    logic wave = ((kk % (1 << MB)) >= (1 << (MB - 1)));
    if (half) p = p / 2;
    else      p = p % per;
    if (off)    return 1'b0;
    if (follow) return det;
    case (duty)
      2'b00:   return mdl ? wave : 1'b1;
      2'b01:   return (p < per / 2);
      2'b10:   return (p < per / 4);
      default: return (p < per / 8);
    endcase
  endfunction

  task automatic checkNow(string req);
    tests++;
    if (redLed !== expRed || blueLed !== expBlue) begin
      fails++;
      $display("FAIL %s k=%0d red act=%b exp=%b blue act=%b exp=%b",
               req, k, redLed, expRed, blueLed, expBlue);
    end
  endtask

  task automatic predict();
    expRed  = lampModel(k, redDuty, redModulate, redOff, halfRate, 1'b0, dataDetect);
    expBlue = lampModel(k, blueDuty, blueModulate, blueOff, halfRate, blueFollow, dataDetect);
    k++;
  endtask

  task automatic runPhase(string req, logic [1:0] rd, logic [1:0] bd, logic rm, logic bm,
                          logic ro, logic bo, logic bf, logic hr, bit tog, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkNow(curReq);
      if (i == 0) begin
        // R8: new settings take effect at the next rising edge
        redDuty = rd; blueDuty = bd; redModulate = rm; blueModulate = bm;
        redOff = ro; blueOff = bo; blueFollow = bf; halfRate = hr;
        toggleDetect = tog; curReq = req;
      end
      if (toggleDetect && (k % 7 == 3)) dataDetect = ~dataDetect;
      predict();
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    checkNow(curReq);
    rstN = 1'b0;
    curReq = "R1";
    expRed = 1'b0; expBlue = 1'b0;
    repeat (3) begin
      @(negedge clk);
      checkNow("R1");
    end
    rstN = 1'b1;
    #0.1;
    checkNow("R1");  // R1: still dark before first edge after release
    k = 0;
    predict();
  endtask

  initial begin
    rstN = 1'b0;
    redDuty = 2'b00; blueDuty = 2'b00; redModulate = 1'b0; blueModulate = 1'b0;
    redOff = 1'b0; blueOff = 1'b0; blueFollow = 1'b0; halfRate = 1'b0; dataDetect = 1'b0;
    repeat (3) begin
      @(negedge clk);
      checkNow("R1");
    end
    rstN = 1'b1;
    #0.1;
    checkNow("R1");
    k = 0;
    predict();
    runPhase("R2 R3", 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 600);
    runPhase("R3",    2'b10, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 600);
    runPhase("R5",    2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 120);
    runPhase("R4 R5", 2'b01, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 1200);
    runPhase("R7 R6", 2'b00, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1, 300);
    runPhase("R6",    2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1, 100);
    runPhase("R4",    2'b11, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 1100);
    runPhase("R8",    2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 300);
    doReset();
    runPhase("R1 R3", 2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 300);
    @(negedge clk);
    checkNow(curReq);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at k=%0d", k);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule